// File: doc/BRIEF.md
# Burst Byte-Enable Legality Checker

This block watches a 32-bit memory-mapped request channel and judges the byte-enable pattern of every data phase that crosses it. A phase is accepted only when the channel's valid and ready are both high. The block never stalls the channel. It observes the handshake and takes no part in it, so back-pressure belongs entirely to the channel: while ready is low, nothing is counted and nothing is reported.

The rule a pattern must meet depends on where the phase sits. A stand-alone transfer must use a naturally aligned power-of-two group of lanes. A burst must cover a contiguous run of bytes. Its opening phase therefore has to reach the top lane, its closing phase has to start at lane 0, and every phase in between must enable all four lanes. The block loads a beat counter from the burst length on the opening phase and uses it to tell the middle phases from the closing one. It also checks the end-of-burst marker against that count.

For each accepted phase the block raises a one-cycle done pulse on the next clock. The pulse comes with an illegal flag and a code that names the class of the phase that was judged.

Top module: `be_legal_chk`

## Requirements
- R1: A phase is accepted only in a cycle where `bus_valid` and `bus_ready` are both 1. In any other cycle the enables, markers and length are ignored, and the burst position does not advance.
- R2: One clock after an accepted phase, `chk_done` is 1 for exactly one cycle. `chk_phase` then gives the class of that phase (0 single, 1 first, 2 middle, 3 last), and `chk_illegal` is 1 if the phase broke a rule. When no phase was accepted, `chk_done` and `chk_illegal` are 0.
- R3: A single phase is legal only with enables 4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b0011, 4'b1100 or 4'b1111.
- R4: A first phase is legal only with enables 4'b1000, 4'b1100, 4'b1110 or 4'b1111.
- R5: A middle phase is legal only with enables 4'b1111.
- R6: A last phase is legal only with enables 4'b0001, 4'b0011, 4'b0111 or 4'b1111.
- R7: Enables of 4'b0000 are illegal in every phase class.
- R8: Outside a burst, an accepted phase with `bus_sob`=1 and `bus_len` of 2 or more is a first phase. Outside a burst, any other accepted phase is a single phase, including one with `bus_len` of 0 or 1.
- R9: After a first phase with length L, the next L-2 accepted phases are middle phases and the one after them is the last phase. Once the last phase has been accepted, the burst is over. Inside a burst, `bus_sob` and `bus_len` are ignored.
- R10: `bus_eob` must be 1 on single and last phases and 0 on first and middle phases. A mismatch makes the phase illegal.
- R11: Synchronous active-high `rst` ends any burst in progress and clears `chk_done` and `chk_illegal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | Channel valid |
| bus_ready | input | 1 | Channel ready, observed only |
| bus_be | input | 4 | Byte enables of the phase |
| bus_sob | input | 1 | Start-of-burst marker |
| bus_eob | input | 1 | End-of-burst marker |
| bus_len | input | 8 | Burst length in phases, sampled with the start marker |
| chk_done | output | 1 | Result strobe, one cycle after an accepted phase |
| chk_illegal | output | 1 | Phase broke a byte-enable or marker rule |
| chk_phase | output | 2 | Class of the judged phase |

## Verification
Every result arrives exactly one clock after the phase it judges, because a single register stage lies between the handshake and the outputs. The bench drives each phase on a falling edge and lets one rising edge capture it. It then samples the outputs 1 ns after that rising edge, which is the one cycle in which the done pulse is visible. Stalled cycles and reset cycles are checked the same way, in the cycle that follows, to confirm that no pulse appears and that the burst position has not moved.

// File: rtl/be_chk_pkg.sv
package be_chk_pkg;
  typedef enum logic [1:0] {
    PH_SINGLE = 2'd0,
    PH_FIRST  = 2'd1,
    PH_MIDDLE = 2'd2,
    PH_LAST   = 2'd3
  } be_phase_e;
endpackage

// File: rtl/be_phase_tracker.sv
module be_phase_tracker
  import be_chk_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             beat,
  input  logic             sob,
  input  logic [LEN_W-1:0] len,
  output be_phase_e        phase
);
  logic             in_burst;
  logic [LEN_W-1:0] remain;

  // Class the current phase from the burst position
  always_comb begin
    if (!in_burst)
      phase = (sob && len > LEN_W'(1)) ? PH_FIRST : PH_SINGLE;
    else
      phase = (remain == LEN_W'(1)) ? PH_LAST : PH_MIDDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_burst <= 1'b0;
      remain   <= '0;
    end else if (beat) begin
      case (phase)
        PH_FIRST: begin
          in_burst <= 1'b1;
          remain   <= len - LEN_W'(1);
        end
        PH_MIDDLE: remain <= remain - LEN_W'(1);
        PH_LAST: begin
          in_burst <= 1'b0;
          remain   <= '0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/be_pattern_rule.sv
module be_pattern_rule
  import be_chk_pkg::*;
#(
  parameter int LANES = 4
) (
  input  be_phase_e        phase,
  input  logic [LANES-1:0] be,
  output logic             ok
);
  localparam int NSIZE = $clog2(LANES) + 1;
  localparam logic [LANES-1:0] ALL = {LANES{1'b1}};

  logic [LANES-1:0] top_hit;
  logic [LANES-1:0] low_hit;
  logic [NSIZE-1:0] size_hit;

  // Runs anchored at the top lane or at lane 0
  for (genvar k = 0; k < LANES; k++) begin : g_run
    assign top_hit[k] = (be == (ALL << k));
    assign low_hit[k] = (be == (ALL >> k));
  end

  // Naturally aligned groups of 2^s lanes
  for (genvar s = 0; s < NSIZE; s++) begin : g_size
    localparam int GW = 1 << s;
    localparam logic [LANES-1:0] GMASK = LANES'((1 << GW) - 1);
    logic [LANES-1:0] off_hit;
    for (genvar o = 0; o < LANES; o++) begin : g_off
      if (o < LANES / GW) begin : g_on
        assign off_hit[o] = (be == (GMASK << (o * GW)));
      end else begin : g_off_none
        assign off_hit[o] = 1'b0;
      end
    end
    assign size_hit[s] = |off_hit;
  end

  always_comb begin
    case (phase)
      PH_SINGLE: ok = |size_hit;
      PH_FIRST:  ok = |top_hit;
      PH_MIDDLE: ok = (be == ALL);
      PH_LAST:   ok = |low_hit;
      default:   ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/be_legal_chk.sv
module be_legal_chk
  import be_chk_pkg::*;
#(
  parameter int LANES = 4,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_valid,
  input  logic             bus_ready,
  input  logic [LANES-1:0] bus_be,
  input  logic             bus_sob,
  input  logic             bus_eob,
  input  logic [LEN_W-1:0] bus_len,
  output logic             chk_done,
  output logic             chk_illegal,
  output logic [1:0]       chk_phase
);
  logic      beat;
  be_phase_e phase;
  logic      pat_ok;
  logic      eob_want;
  logic      bad;

  assign beat = bus_valid & bus_ready;

  be_phase_tracker #(.LEN_W(LEN_W)) u_track (
    .clk   (clk),
    .rst   (rst),
    .beat  (beat),
    .sob   (bus_sob),
    .len   (bus_len),
    .phase (phase)
  );

  be_pattern_rule #(.LANES(LANES)) u_rule (
    .phase (phase),
    .be    (bus_be),
    .ok    (pat_ok)
  );

  assign eob_want = (phase == PH_SINGLE) || (phase == PH_LAST);
  assign bad      = !pat_ok || (bus_eob != eob_want);

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_done    <= 1'b0;
      chk_illegal <= 1'b0;
      chk_phase   <= 2'd0;
    end else begin
      chk_done    <= beat;
      chk_illegal <= beat & bad;
      if (beat) chk_phase <= phase;
    end
  end
endmodule

// File: rtl/be_legal_chk_sva.sv
module be_legal_chk_sva #(
  parameter int LANES = 4,
  parameter int LEN_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_valid,
  input logic             bus_ready,
  input logic [LANES-1:0] bus_be,
  input logic             chk_done,
  input logic             chk_illegal,
  input logic [1:0]       chk_phase
);
  // R2
  beat_reported_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_ready) |=> chk_done);

  // R1
  stall_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_valid && bus_ready) |=> !chk_done);

  // R2
  illegal_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
    chk_illegal |-> chk_done);

  // R7
  zero_be_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_ready && bus_be == '0) |=> chk_illegal);

  // R5
  middle_full_chk: assert property (@(posedge clk) disable iff (rst)
    (chk_done && chk_phase == 2'd2 && $past(bus_be) != {LANES{1'b1}}) |-> chk_illegal);

  // R11
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!chk_done && !chk_illegal));
endmodule

bind be_legal_chk be_legal_chk_sva #(.LANES(LANES), .LEN_W(LEN_W)) u_sva (
  .clk         (clk),
  .rst         (rst),
  .bus_valid   (bus_valid),
  .bus_ready   (bus_ready),
  .bus_be      (bus_be),
  .chk_done    (chk_done),
  .chk_illegal (chk_illegal),
  .chk_phase   (chk_phase)
);

// File: tb/tb_be_legal_chk.sv
module tb_be_legal_chk;
  logic       clk = 1'b0;
  logic       rst;
  logic       bus_valid, bus_ready, bus_sob, bus_eob;
  logic [3:0] bus_be;
  logic [7:0] bus_len;
  logic       chk_done, chk_illegal;
  logic [1:0] chk_phase;
  int checks = 0;
  int fails  = 0;

  localparam logic [1:0] SGL = 2'd0, FST = 2'd1, MID = 2'd2, LST = 2'd3;

  always #2 clk = ~clk;

  be_legal_chk dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_be(bus_be), .bus_sob(bus_sob), .bus_eob(bus_eob), .bus_len(bus_len),
    .chk_done(chk_done), .chk_illegal(chk_illegal), .chk_phase(chk_phase)
  );

  function automatic logic single_ok(input logic [3:0] b);
    case (b)
      4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b0011, 4'b1100, 4'b1111: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic first_ok(input logic [3:0] b);
    return b == 4'b1000 || b == 4'b1100 || b == 4'b1110 || b == 4'b1111;
  endfunction

  function automatic logic last_ok(input logic [3:0] b);
    return b == 4'b0001 || b == 4'b0011 || b == 4'b0111 || b == 4'b1111;
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    bus_valid = 1'b0; bus_ready = 1'b1; bus_sob = 1'b0; bus_eob = 1'b0;
    bus_be = 4'b0000; bus_len = 8'd0;
  endtask

  // Drive one accepted phase, then check the registered result 1 ns after the edge
  task automatic beat(input string req, input logic [3:0] be, input logic sob,
                      input logic eob, input logic [7:0] len,
                      input logic exp_bad, input logic [1:0] exp_ph);
    @(negedge clk);
    bus_valid = 1'b1; bus_ready = 1'b1; bus_be = be;
    bus_sob = sob; bus_eob = eob; bus_len = len;
    @(posedge clk); #1;
    check(req, {3'b0, chk_done}, 4'd1);
    check(req, {3'b0, chk_illegal}, {3'b0, exp_bad});
    check(req, {2'b0, chk_phase}, {2'b0, exp_ph});
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    bus_valid = 1'b0; bus_ready = 1'b0; bus_sob = 1'b0; bus_eob = 1'b0;
    bus_be = 4'b0000; bus_len = 8'd0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R11 reset done", {3'b0, chk_done}, 4'd0);
    check("R11 reset illegal", {3'b0, chk_illegal}, 4'd0);
  endtask

  task automatic t_single_sweep();
    for (int i = 0; i < 16; i++)
      beat("R3 single sweep", 4'(i), 1'b0, 1'b1, 8'd0, !single_ok(4'(i)), SGL);
    beat("R7 single zero", 4'b0000, 1'b0, 1'b1, 8'd0, 1'b1, SGL);
    idle();
  endtask

  task automatic t_first_sweep();
    for (int i = 0; i < 16; i++) begin
      beat("R4 first sweep", 4'(i), 1'b1, 1'b0, 8'd2, !first_ok(4'(i)), FST);
      beat("R9 close len2", 4'b1111, 1'b0, 1'b1, 8'd0, 1'b0, LST);
    end
    idle();
  endtask

  task automatic t_last_sweep();
    for (int i = 0; i < 16; i++) begin
      beat("R8 open len3", 4'b1100, 1'b1, 1'b0, 8'd3, 1'b0, FST);
      beat("R9 mid len3", 4'b1111, 1'b0, 1'b0, 8'd0, 1'b0, MID);
      beat("R6 last sweep", 4'(i), 1'b0, 1'b1, 8'd0, !last_ok(4'(i)), LST);
    end
    idle();
  endtask

  task automatic t_middle_rules();
    beat("R8 open len5", 4'b1111, 1'b1, 1'b0, 8'd5, 1'b0, FST);
    beat("R5 mid 0111", 4'b0111, 1'b0, 1'b0, 8'd0, 1'b1, MID);
    beat("R7 mid zero", 4'b0000, 1'b0, 1'b0, 8'd0, 1'b1, MID);
    beat("R5 mid full", 4'b1111, 1'b1, 1'b0, 8'd9, 1'b0, MID);  // R9 sob ignored
    beat("R9 last len5", 4'b0001, 1'b0, 1'b1, 8'd0, 1'b0, LST);
    beat("R9 after burst", 4'b0010, 1'b0, 1'b1, 8'd0, 1'b0, SGL);
    idle();
  endtask

  task automatic t_len_one();
    beat("R8 sob len1", 4'b1100, 1'b1, 1'b1, 8'd1, 1'b0, SGL);
    beat("R8 sob len0", 4'b1110, 1'b1, 1'b1, 8'd0, 1'b1, SGL);
    idle();
  endtask

  task automatic t_eob_rules();
    beat("R10 single no eob", 4'b1111, 1'b0, 1'b0, 8'd0, 1'b1, SGL);
    beat("R10 first with eob", 4'b1111, 1'b1, 1'b1, 8'd3, 1'b1, FST);
    beat("R10 mid with eob", 4'b1111, 1'b0, 1'b1, 8'd0, 1'b1, MID);
    beat("R10 last no eob", 4'b0011, 1'b0, 1'b0, 8'd0, 1'b1, LST);
    idle();
  endtask

  task automatic t_stall();
    beat("R8 open len3 stall", 4'b1000, 1'b1, 1'b0, 8'd3, 1'b0, FST);
    @(negedge clk);
    bus_valid = 1'b1; bus_ready = 1'b0; bus_be = 4'b0000; bus_eob = 1'b1;
    @(posedge clk); #1;
    check("R1 not ready", {3'b0, chk_done}, 4'd0);
    @(negedge clk);
    bus_valid = 1'b0; bus_ready = 1'b1;
    @(posedge clk); #1;
    check("R1 not valid", {3'b0, chk_done}, 4'd0);
    check("R2 no illegal idle", {3'b0, chk_illegal}, 4'd0);
    beat("R1 mid after stall", 4'b1111, 1'b0, 1'b0, 8'd0, 1'b0, MID);
    beat("R1 last after stall", 4'b0111, 1'b0, 1'b1, 8'd0, 1'b0, LST);
    idle();
  endtask

  task automatic t_reset_mid_burst();
    beat("R8 open len4 rst", 4'b1111, 1'b1, 1'b0, 8'd4, 1'b0, FST);
    do_reset();
    check("R11 cleared done", {3'b0, chk_done}, 4'd0);
    beat("R11 burst ended", 4'b0100, 1'b0, 1'b1, 8'd0, 1'b0, SGL);
    idle();
  endtask

  initial begin
    rst = 1'b1;
    bus_valid = 1'b0; bus_ready = 1'b0; bus_sob = 1'b0; bus_eob = 1'b0;
    bus_be = 4'b0000; bus_len = 8'd0;
    t_reset_state();
    t_single_sweep();
    t_first_sweep();
    t_last_sweep();
    t_middle_rules();
    t_len_one();
    t_eob_rules();
    t_stall();
    t_reset_mid_burst();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule